// File: doc/BRIEF.md
# PLL Divider Parameter Search Engine

This block takes a target PLL output frequency in kHz and, after a start pulse, works out a set of divider values that synthesise it from a fixed reference oscillator (24 MHz by default). It returns four values:

- a reference divider `nr`;
- a feedback divider `nf`;
- an even (or unit) post divider `no`;
- an extra divider `ext_div` that sits after the PLL for very low targets.

The search first sizes the post division so that the VCO lands inside its legal window. It then walks the reference divider upward. For each reference divider it takes the feedback divider that comes nearest to the VCO frequency and keeps the best one.

All quotients come from one shared iterative divider that yields one bit per clock, so a search takes a few hundred to a few thousand cycles. A one-cycle `done` pulse closes every search, and `fail` tells a good result from a rejected one. Results stay on the outputs until the next search completes.

Top module: `pll_div_search`

## Requirements
- R1: A start with a target of 0 ends the search in the next cycle with `done` and `fail` both high.
- R2: The post divider is found in four steps. First, p = ceil(440000 / target). Second, `ext_div` = ceil(p / 16). Third, `no` = ceil(p / `ext_div`). Fourth, if `no` > 1 and is odd, it is raised by one. A successful result therefore has `no` equal to 1 or to an even value.
- R3: With VCO = target × `no` × `ext_div`, the search fails if the VCO lies outside 440000..2200000 kHz or if `no` exceeds 16.
- R4: `nr` is tried as 1, 2, 3 and so on, staying below the sweep limit (64 by default). The candidate reference frequency is fref = floor(24000 / `nr`). The sweep stops when fref < 269 kHz, and any `nr` with fref > 2200000 kHz is skipped.
- R5: For each tried `nr`, `nf` = floor(VCO / fref) and the error is the remainder. The candidate is dropped if `nf` ≥ 4096. If the remainder exceeds floor(fref / 2) and `nf` + 1 < 4096, `nf` is raised by one and the error becomes fref minus the remainder.
- R6: A candidate replaces the kept one only when its error is strictly smaller, so ties keep the lowest `nr`. The sweep stops as soon as the kept error is zero.
- R7: The search fails when the best error left at the end is above 4000 kHz.
- R8: `done` is a single-cycle pulse at the end of every search, good or failed. `fail`, `nr`, `nf`, `no` and `ext_div` change only in a cycle where `done` is high.
- R9: A start seen while a search runs has no effect on that search or its result. A start in the same cycle as `done` begins a new search.
- R10: On failure `nr`, `nf`, `no` and `ext_div` all read 0. On success `nr` is at least 1.
- R11: After reset, `done`, `fail` and all divider outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; sampled only when idle |
| target_khz | input | TGT_W | Wanted output frequency in kHz, captured with start |
| done | output | 1 | One-cycle end-of-search pulse |
| fail | output | 1 | Search found no acceptable setting |
| nr | output | clog2(NR_LIMIT) | Reference divider |
| nf | output | clog2(NF_LIMIT) | Feedback divider |
| no | output | clog2(NO_LIMIT+1) | Post divider |
| ext_div | output | TGT_W | Extra divider after the PLL |

## Verification
The cycle that ends one search and raises `done` is also the first cycle in which the engine is idle again. A start can therefore arrive in the very cycle of the completion pulse. The bench provokes this by watching for `done` and driving a new start with a different target in that same cycle. It then judges that the old result was visible in that cycle, that `done` fell in the next cycle, and that the following completion carries the result for the second target. A second case holds a start with another target in the middle of a running search, and expects the first target's result together with exactly one pulse.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POST,
    ST_EXTRA,
    ST_TRIM,
    ST_VCO,
    ST_FREF,
    ST_FB
  } srch_state_e;

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quot,
  output logic [W-1:0] remd
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fin_q, fin_d;
  logic [W:0]    shifted;
  logic [W:0]    trial;
  logic          fits;

  assign shifted = {rem_q, quo_q[W-1]};
  assign trial   = shifted - {1'b0, dvs_q};
  assign fits    = shifted >= {1'b0, dvs_q};

  always_comb begin
    quo_d = quo_q;
    rem_d = rem_q;
    dvs_d = dvs_q;
    cnt_d = cnt_q;
    fin_d = 1'b0;
    if (go) begin
      quo_d = dividend;
      rem_d = '0;
      dvs_d = divisor;
      cnt_d = CW'(W);
    end else if (cnt_q != '0) begin
      rem_d = fits ? trial[W-1:0] : shifted[W-1:0];
      quo_d = {quo_q[W-2:0], fits};
      cnt_d = cnt_q - CW'(1);
      fin_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else begin
      quo_q <= quo_d;
      rem_q <= rem_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
      fin_q <= fin_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign fin  = fin_q;
  assign quot = quo_q;
  assign remd = rem_q;

  // R5: every quotient is taken against a nonzero divisor
  a_r5_div_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (divisor != '0));

  // R9: the shared divider is never relaunched while it is still working
  a_r9_div_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);

  // R5: a finished division leaves a remainder below the divisor
  a_r5_rem_below: assert property (@(posedge clk) disable iff (!rst_n)
    fin |-> (remd < dvs_q));

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
  parameter int W        = 24,
  parameter int NF_LIMIT = 4096
) (
  input  logic [W-1:0] quo,
  input  logic [W-1:0] rem,
  input  logic [W-1:0] fref,
  input  logic [W-1:0] best,
  output logic [W-1:0] nf_c,
  output logic [W-1:0] diff_c,
  output logic         take
);

  logic usable;
  logic round_up;

  always_comb begin
    usable   = quo < W'(NF_LIMIT);
    round_up = usable && (rem > (fref >> 1)) && ((quo + W'(1)) < W'(NF_LIMIT));
    nf_c     = round_up ? quo + W'(1) : quo;
    diff_c   = round_up ? fref - rem : rem;
    take     = usable && (diff_c < best);
  end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pll_search_pkg::*;
#(
  parameter int REF_KHZ      = 24000,
  parameter int VCO_MIN_KHZ  = 440000,
  parameter int VCO_MAX_KHZ  = 2200000,
  parameter int FREF_MIN_KHZ = 269,
  parameter int FREF_MAX_KHZ = 2200000,
  parameter int NR_LIMIT     = 64,
  parameter int NF_LIMIT     = 4096,
  parameter int NO_LIMIT     = 16,
  parameter int TOL_KHZ      = 4000,
  parameter int TGT_W        = 24
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [TGT_W-1:0]              target_khz,
  output logic                          done,
  output logic                          fail,
  output logic [$clog2(NR_LIMIT)-1:0]   nr,
  output logic [$clog2(NF_LIMIT)-1:0]   nf,
  output logic [$clog2(NO_LIMIT+1)-1:0] no,
  output logic [TGT_W-1:0]              ext_div
);

  localparam int NR_W = $clog2(NR_LIMIT);
  localparam int NF_W = $clog2(NF_LIMIT);
  localparam int NO_W = $clog2(NO_LIMIT + 1);
  localparam int PW   = 3 * TGT_W;

  srch_state_e st_q, st_d;
  logic [TGT_W-1:0] tgt_q, tgt_d;
  logic [TGT_W-1:0] no_q, no_d;
  logic [TGT_W-1:0] ext_q, ext_d;
  logic [TGT_W-1:0] vco_q, vco_d;
  logic [TGT_W-1:0] best_q, best_d;
  logic [NR_W:0]    nr_q, nr_d;
  logic [NR_W-1:0]  bnr_q, bnr_d;
  logic [NF_W-1:0]  bnf_q, bnf_d;

  logic                done_q, done_d;
  logic                fail_q, fail_d;
  logic [NR_W-1:0]     nr_o_q, nr_o_d;
  logic [NF_W-1:0]     nf_o_q, nf_o_d;
  logic [NO_W-1:0]     no_o_q, no_o_d;
  logic [TGT_W-1:0]    ext_o_q, ext_o_d;

  logic             div_go;
  logic [TGT_W-1:0] div_a, div_b;
  logic             div_busy, div_fin;
  logic [TGT_W-1:0] div_q, div_r;
  logic [TGT_W-1:0] cq;
  logic [PW-1:0]    vco_w;
  logic [TGT_W-1:0] cand_nf, cand_diff;
  logic             cand_take;
  logic             fin_err, fin_eval, advance;
  logic [NR_W:0]    nr_nx;

  pll_seq_div #(.W(TGT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_a),
    .divisor  (div_b),
    .busy     (div_busy),
    .fin      (div_fin),
    .quot     (div_q),
    .remd     (div_r)
  );

  pll_cand_eval #(.W(TGT_W), .NF_LIMIT(NF_LIMIT)) u_eval (
    .quo    (div_q),
    .rem    (div_r),
    .fref   (div_b_hold),
    .best   (best_q),
    .nf_c   (cand_nf),
    .diff_c (cand_diff),
    .take   (cand_take)
  );

  // the fref used by the current feedback division is the registered one
  logic [TGT_W-1:0] div_b_hold;
  logic [TGT_W-1:0] fref_q, fref_d;
  assign div_b_hold = fref_q;

  assign cq    = div_q + {{(TGT_W-1){1'b0}}, |div_r};
  assign vco_w = PW'(tgt_q) * PW'(no_q) * PW'(ext_q);
  assign nr_nx = nr_q + (NR_W+1)'(1);

  always_comb begin
    st_d     = st_q;
    tgt_d    = tgt_q;
    no_d     = no_q;
    ext_d    = ext_q;
    vco_d    = vco_q;
    fref_d   = fref_q;
    best_d   = best_q;
    nr_d     = nr_q;
    bnr_d    = bnr_q;
    bnf_d    = bnf_q;
    done_d   = 1'b0;
    fail_d   = fail_q;
    nr_o_d   = nr_o_q;
    nf_o_d   = nf_o_q;
    no_o_d   = no_o_q;
    ext_o_d  = ext_o_q;
    div_go   = 1'b0;
    div_a    = '0;
    div_b    = '0;
    fin_err  = 1'b0;
    fin_eval = 1'b0;
    advance  = 1'b0;

    case (st_q)
      ST_IDLE: begin
        if (start) begin
          tgt_d = target_khz;
          if (target_khz == '0) begin
            fin_err = 1'b1;
          end else begin
            div_go = 1'b1;
            div_a  = TGT_W'(VCO_MIN_KHZ);
            div_b  = target_khz;
            st_d   = ST_POST;
          end
        end
      end
      ST_POST: begin
        if (div_fin) begin
          no_d   = cq;
          div_go = 1'b1;
          div_a  = cq;
          div_b  = TGT_W'(NO_LIMIT);
          st_d   = ST_EXTRA;
        end
      end
      ST_EXTRA: begin
        if (div_fin) begin
          ext_d  = cq;
          div_go = 1'b1;
          div_a  = no_q;
          div_b  = cq;
          st_d   = ST_TRIM;
        end
      end
      ST_TRIM: begin
        if (div_fin) begin
          no_d = (cq > TGT_W'(1) && cq[0]) ? cq + TGT_W'(1) : cq;
          st_d = ST_VCO;
        end
      end
      ST_VCO: begin
        if (vco_w < PW'(VCO_MIN_KHZ) || vco_w > PW'(VCO_MAX_KHZ) ||
            no_q > TGT_W'(NO_LIMIT)) begin
          fin_err = 1'b1;
        end else begin
          vco_d  = vco_w[TGT_W-1:0];
          best_d = vco_w[TGT_W-1:0];
          bnr_d  = '0;
          bnf_d  = '0;
          nr_d   = (NR_W+1)'(1);
          div_go = 1'b1;
          div_a  = TGT_W'(REF_KHZ);
          div_b  = TGT_W'(1);
          st_d   = ST_FREF;
        end
      end
      ST_FREF: begin
        if (div_fin) begin
          if (div_q < TGT_W'(FREF_MIN_KHZ)) begin
            fin_eval = 1'b1;
          end else if (div_q > TGT_W'(FREF_MAX_KHZ)) begin
            advance = 1'b1;
          end else begin
            fref_d = div_q;
            div_go = 1'b1;
            div_a  = vco_q;
            div_b  = div_q;
            st_d   = ST_FB;
          end
        end
      end
      ST_FB: begin
        if (div_fin) begin
          if (cand_take) begin
            best_d = cand_diff;
            bnr_d  = nr_q[NR_W-1:0];
            bnf_d  = cand_nf[NF_W-1:0];
          end
          advance = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase

    if (advance) begin
      if (nr_nx >= (NR_W+1)'(NR_LIMIT) || best_d == '0) begin
        fin_eval = 1'b1;
      end else begin
        nr_d   = nr_nx;
        div_go = 1'b1;
        div_a  = TGT_W'(REF_KHZ);
        div_b  = TGT_W'(nr_nx);
        st_d   = ST_FREF;
      end
    end

    if (fin_err || fin_eval) begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
      fail_d = fin_err || (best_d > TGT_W'(TOL_KHZ));
      if (fail_d) begin
        nr_o_d  = '0;
        nf_o_d  = '0;
        no_o_d  = '0;
        ext_o_d = '0;
      end else begin
        nr_o_d  = bnr_d;
        nf_o_d  = bnf_d;
        no_o_d  = no_q[NO_W-1:0];
        ext_o_d = ext_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tgt_q   <= '0;
      no_q    <= '0;
      ext_q   <= '0;
      vco_q   <= '0;
      fref_q  <= '0;
      best_q  <= '0;
      nr_q    <= '0;
      bnr_q   <= '0;
      bnf_q   <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      nr_o_q  <= '0;
      nf_o_q  <= '0;
      no_o_q  <= '0;
      ext_o_q <= '0;
    end else begin
      st_q    <= st_d;
      tgt_q   <= tgt_d;
      no_q    <= no_d;
      ext_q   <= ext_d;
      vco_q   <= vco_d;
      fref_q  <= fref_d;
      best_q  <= best_d;
      nr_q    <= nr_d;
      bnr_q   <= bnr_d;
      bnf_q   <= bnf_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      nr_o_q  <= nr_o_d;
      nf_o_q  <= nf_o_d;
      no_o_q  <= no_o_d;
      ext_o_q <= ext_o_d;
    end
  end

  assign done    = done_q;
  assign fail    = fail_q;
  assign nr      = nr_o_q;
  assign nf      = nf_o_q;
  assign no      = no_o_q;
  assign ext_div = ext_o_q;

  // R1: a zero target is answered in the very next cycle as a failure
  a_r1_zero_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && start && target_khz == '0) |=> (done && fail));

  // R8: results move only together with the completion pulse
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (done || ($stable(nr) && $stable(nf) && $stable(no) &&
                       $stable(ext_div) && $stable(fail))));

  // R8: the completion pulse lasts one cycle unless a zero target restarts it
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && target_khz == '0)) |=> !done);

  // R10: a failed search reports all dividers as zero
  a_r10_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (nr == '0 && nf == '0 && no == '0 && ext_div == '0));

  // R2: a good result has a unit or even post divider and a nonzero nr
  a_r2_no_even: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fail) |-> ((no == NO_W'(1) || (no != '0 && !no[0])) && nr != '0));

endmodule

// File: tb/pll_div_search_tb_top.sv
module pll_div_search_tb_top;

  localparam int TW = 24;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          st1, st2;
  logic [TW-1:0] tg1, tg2;

  logic          d1, f1, d2, f2;
  logic [5:0]    nr1;
  logic [0:0]    nr2;
  logic [11:0]   nf1, nf2;
  logic [4:0]    no1, no2;
  logic [TW-1:0] ex1, ex2;

  pll_div_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(st1), .target_khz(tg1),
    .done(d1), .fail(f1), .nr(nr1), .nf(nf1), .no(no1), .ext_div(ex1)
  );

  pll_div_search #(.NR_LIMIT(2)) dut2_i (
    .clk(clk), .rst_n(rst_n), .start(st2), .target_khz(tg2),
    .done(d2), .fail(f2), .nr(nr2), .nf(nf2), .no(no2), .ext_div(ex2)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run exceeded cycle budget actual %0d expected <= 190000", cyc);
      finish_up();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint cdiv(input longint a, input longint b);
    return (a + b - 1) / b;
  endfunction

  task automatic model(input longint t, input int lim, output bit e,
                       output longint mnr, output longint mnf,
                       output longint mno, output longint mext);
    longint p, ext, no, vco, best, bnr, bnf;
    e = 0; mnr = 0; mnf = 0; mno = 0; mext = 0;
    if (t == 0) begin e = 1; return; end
    p   = cdiv(440000, t);
    ext = cdiv(p, 16);
    no  = cdiv(p, ext);
    if (no > 1 && (no % 2) == 1) no++;
    vco = t * no * ext;
    if (vco < 440000 || vco > 2200000 || no > 16) begin e = 1; return; end
    best = vco; bnr = 0; bnf = 0;
    for (int r = 1; r < lim && best != 0; r++) begin
      longint fr, q, d;
      fr = 24000 / r;
      if (fr < 269) break;
      if (fr > 2200000) continue;
      q = vco / fr;
      if (q >= 4096) continue;
      d = vco - q * fr;
      if (q + 1 < 4096 && d > fr / 2) begin q++; d = fr - d; end
      if (d < best) begin best = d; bnr = r; bnf = q; end
    end
    if (best > 4000) begin e = 1; return; end
    mnr = bnr; mnf = bnf; mno = no; mext = ext;
  endtask

  task automatic launch(input bit which, input logic [TW-1:0] t);
    @(negedge clk);
    if (which) begin tg2 = t; st2 = 1'b1; end
    else       begin tg1 = t; st1 = 1'b1; end
    @(negedge clk);
    st1 = 1'b0;
    st2 = 1'b0;
  endtask

  task automatic wait_done(input bit which);
    int k = 0;
    while (!(which ? d2 : d1)) begin
      @(negedge clk);
      k++;
      if (k > 20000) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R8 watchdog: no done after %0d cycles expected within 20000", k);
        finish_up();
      end
    end
  endtask

  task automatic compare(input bit which, input longint t, input string req);
    bit e;
    longint enr, enf, eno, eext;
    model(t, which ? 2 : 64, e, enr, enf, eno, eext);
    if (which) begin
      chk(f2 == e, req, $sformatf("fail t=%0d", t), f2, e);
      chk(nr2 == enr, req, $sformatf("nr t=%0d", t), nr2, enr);
      chk(nf2 == enf, req, $sformatf("nf t=%0d", t), nf2, enf);
      chk(no2 == eno, req, $sformatf("no t=%0d", t), no2, eno);
      chk(ex2 == eext, req, $sformatf("ext t=%0d", t), ex2, eext);
    end else begin
      chk(f1 == e, req, $sformatf("fail t=%0d", t), f1, e);
      chk(nr1 == enr, req, $sformatf("nr t=%0d", t), nr1, enr);
      chk(nf1 == enf, req, $sformatf("nf t=%0d", t), nf1, enf);
      chk(no1 == eno, req, $sformatf("no t=%0d", t), no1, eno);
      chk(ex1 == eext, req, $sformatf("ext t=%0d", t), ex1, eext);
    end
  endtask

  task automatic search(input bit which, input longint t, input string req);
    launch(which, TW'(t));
    wait_done(which);
    compare(which, t, req);
    @(negedge clk);
    chk((which ? d2 : d1) == 1'b0, "R8", "done width", which ? d2 : d1, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; st1 = 1'b0; st2 = 1'b0; tg1 = '0; tg2 = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(d1 == 0 && f1 == 0, "R11", "done/fail after reset", {d1, f1}, 0);
    chk(nr1 == 0 && nf1 == 0 && no1 == 0 && ex1 == 0, "R11", "dividers after reset",
        nf1, 0);

    // R1 zero target: done in the cycle after start
    launch(1'b0, '0);
    chk(d1 == 1 && f1 == 1, "R1", "zero target done+fail", {d1, f1}, 3);
    compare(1'b0, 0, "R1 R10");

    // R3 VCO above the window
    search(1'b0, 3000000, "R3 R10");
    // R4 R5 R6 top of the window: exact hit at nr=3
    search(1'b0, 2200000, "R4 R5 R6");
    // R2 lowest target forces the extra divider
    search(1'b0, 1, "R2");
    search(1'b0, 1000, "R2");
    search(1'b0, 27500, "R2 R5");
    search(1'b0, 2184000, "R6");
    search(1'b0, 145000, "R2 R5");

    // R7 with a one-step sweep: error of 8000 kHz is rejected
    search(1'b1, 2200000, "R7 R10");
    search(1'b1, 1000000, "R7");
    search(1'b1, 2184000, "R7 R6");

    // R9 start held in the middle of a running search is ignored
    launch(1'b0, TW'(2200000));
    repeat (5) @(negedge clk);
    tg1 = TW'(1000); st1 = 1'b1;
    @(negedge clk);
    st1 = 1'b0;
    wait_done(1'b0);
    compare(1'b0, 2200000, "R9");
    begin
      bit extra = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (d1) extra = 1;
      end
      chk(!extra, "R9", "extra done after ignored start", extra, 0);
    end
    compare(1'b0, 2200000, "R8 hold");

    // R9 start in the same cycle as done begins a new search
    launch(1'b0, TW'(600000));
    wait_done(1'b0);
    compare(1'b0, 600000, "R9");
    tg1 = TW'(333333); st1 = 1'b1;
    @(negedge clk);
    st1 = 1'b0;
    chk(d1 == 0, "R8", "done after back-to-back start", d1, 0);
    compare(1'b0, 600000, "R8 hold");
    wait_done(1'b0);
    compare(1'b0, 333333, "R9");

    // constrained random targets across and beyond the legal span
    for (int i = 0; i < 16; i++) begin
      longint t;
      if (i % 4 == 0) t = $urandom_range(20000, 1);
      else            t = $urandom_range(2300000, 20000);
      search(1'b0, t, "R4 R5 R6");
    end

    finish_up();
  end

endmodule